// File: doc/BRIEF.md
# Page Table Walker for 64-bit Entry Hierarchies

This block turns a virtual page number into a translation record by reading a tree of 64-bit table entries from memory. A walk runs in one of two modes, chosen when it starts. In four-level mode the walk reads a top level, then a pointer level, then a directory level, then a page table. In three-level mode it reads a small pointer level of four entries, then a directory level, then a page table. The walker has one read outstanding at a time. It checks each returned entry, combines its permission bits with those of the levels above, and builds the address of the next read from the entry's frame field and the next slice of the virtual page number.

An entry seen for the first time with its accessed flag clear is written back with that flag set. The write is issued in the same cycle as the next read. A directory entry with its page-size flag set ends the walk early with a 2 MB mapping. A page-table entry ends it with a 4 KB mapping. The walk finishes with a one-cycle pulse on the translation-insert outputs, or, if an entry fails a check, with a one-cycle fault pulse and a fault code. A host starts a walk with a one-cycle start pulse and waits for `busy_o` to fall.

Entry bit positions used throughout:

| Bit(s) | Meaning |
|---|---|
| 0 | present |
| 1 | writable |
| 2 | user |
| 4 | cache disable |
| 5 | accessed |
| 7 | page size (directory level) or attribute selector (4 KB leaf, three-level mode) |
| 8 | global |
| 51:12 | frame number |
| 63 | no-execute |

Top module: `xlat_walker`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `wr_req_o`, `tlb_vld_o` and `fault_vld_o` are all 0.
- R2: One cycle after an accepted start, `rd_req_o` pulses with `busy_o` high and `rd_nocache_o` low. In four-level mode the read address is (base << 12) + vpn[35:27]*8. In three-level mode it is (base << 5) + vpn[19:18]*8. `busy_o` stays high until the cycle in which `tlb_vld_o` or `fault_vld_o` pulses, and is low in that cycle.
- R3: One cycle after `rd_vld_i` returns a non-final entry, the next read is issued at (entry[51:12] << 12) + index*8. In four-level mode the index is vpn[26:18], then vpn[17:9], then vpn[8:0]. In three-level mode it is vpn[17:9], then vpn[8:0].
- R4: An entry with bit 5 clear is written back with bit 5 set when it leads to a further read. The write uses `wr_addr_o` equal to the entry's own read address, and `wr_req_o` pulses in the same cycle as the next `rd_req_o`. The three-level pointer level, final entries, and entries with bit 5 already set produce no write.
- R5: A directory-level entry with bit 7 set ends the walk with a 2 MB page. `tlb_big_o`=1, `tlb_pa_o` = entry[51:21] << 21, `tlb_pat_o` = entry[12], and `tlb_vpn_o` has bits 8:0 cleared.
- R6: A page-table entry ends the walk with a 4 KB page. `tlb_big_o`=0, `tlb_pa_o` = entry[51:12] << 12, and `tlb_vpn_o` equals the start vpn. `tlb_pat_o` is entry[12] in four-level mode and entry[7] in three-level mode.
- R7: `tlb_wr_o` is the AND of bit 1 and `tlb_user_o` the AND of bit 2 over every level in four-level mode, and over the directory and page-table levels only in three-level mode. `tlb_nx_o` is bit 63 of the four-level top entry, and 0 in three-level mode.
- R8: `rd_nocache_o` of each read after the first equals bit 4 of the entry that produced its address. `tlb_nocache_o` is bit 4 and `tlb_glb_o` is bit 8 of the final entry.
- R9: An entry with bit 63 set while `start_nx_en_i` was 0 faults with code 2. This check is skipped at the three-level pointer level. Otherwise an entry with bit 0 clear faults with code 1, so code 2 wins when both apply. A fault pulses `fault_vld_o` once, gives no `tlb_vld_o` and no further read or write, and drops `busy_o`.
- R10: `start_i` asserted while `busy_o` is high is ignored. The running walk keeps its addresses and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| start_vpn_i | input | 36 | Virtual page number to translate |
| start_base_i | input | 40 | Root table base (frame in four-level, 32-byte units in three-level) |
| start_long_i | input | 1 | 1 = four-level mode, 0 = three-level mode |
| start_nx_en_i | input | 1 | No-execute support enabled |
| busy_o | output | 1 | Walk in progress |
| rd_req_o | output | 1 | One-cycle read request |
| rd_addr_o | output | 52 | Read byte address |
| rd_nocache_o | output | 1 | Read is uncacheable |
| rd_vld_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Returned table entry |
| wr_req_o | output | 1 | One-cycle accessed-flag write-back |
| wr_addr_o | output | 52 | Write-back byte address |
| wr_data_o | output | 64 | Entry with accessed flag set |
| tlb_vld_o | output | 1 | Translation insert pulse |
| tlb_vpn_o | output | 36 | Virtual page number aligned to the page size |
| tlb_pa_o | output | 52 | Physical page base address |
| tlb_big_o | output | 1 | 1 = 2 MB page, 0 = 4 KB page |
| tlb_wr_o | output | 1 | Combined writable permission |
| tlb_user_o | output | 1 | Combined user permission |
| tlb_nx_o | output | 1 | No-execute flag |
| tlb_glb_o | output | 1 | Global flag |
| tlb_nocache_o | output | 1 | Mapping is uncacheable |
| tlb_pat_o | output | 1 | Attribute-table selector bit |
| fault_vld_o | output | 1 | Fault pulse |
| fault_code_o | output | 2 | 1 = not present, 2 = no-execute violation |

## Verification
A wrong level register or mode bit shows at the next `rd_req_o`, one cycle after the response. The address takes the wrong slice of the page number, and the walk ends one level early or late. A wrong permission or no-execute accumulator stays hidden through the whole walk and appears only in the `tlb_*` fields of the final pulse. Comparing every insert record against a computed one therefore covers it. A wrong accessed-flag decision shows as a missing or extra `wr_req_o` beside the next read, and a bad fault priority shows as a wrong `fault_code_o` on the first offending entry.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int OFF_W     = 12;  // 4 KB page offset bits
  localparam int IDX_W     = 9;   // index bits per level
  localparam int ENT_W     = 64;
  localparam int ENT_SH    = 3;   // log2 of entry bytes
  localparam int PAE_TOP_W = 2;   // three-level pointer index bits
  localparam int PAE_SH    = 5;   // three-level root base shift

  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_PCD  = 4;
  localparam int B_ACC  = 5;
  localparam int B_PS   = 7;
  localparam int B_GLB  = 8;
  localparam int B_PAT  = 12;
  localparam int B_NX   = 63;

  typedef enum logic [1:0] {
    LV_PT  = 2'd0,
    LV_PD  = 2'd1,
    LV_PDP = 2'd2,
    LV_TOP = 2'd3
  } lvl_e;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_NOTPRES = 2'd1,
    FC_NOEXEC  = 2'd2
  } fcode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } st_e;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
  import xlat_pkg::*;
#(
  parameter int VPN_W = 36,
  parameter int PA_W  = 52
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  lvl_e             lvl_i,
  input  logic             long_i,
  input  logic [PA_W-1:0]  tbl_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    case (lvl_i)
      LV_TOP:  idx = vpn_i[3*IDX_W +: IDX_W];
      LV_PDP:  idx = long_i ? vpn_i[2*IDX_W +: IDX_W]
                            : IDX_W'(vpn_i[2*IDX_W +: PAE_TOP_W]);
      LV_PD:   idx = vpn_i[IDX_W +: IDX_W];
      default: idx = vpn_i[0 +: IDX_W];
    endcase
  end

  assign addr_o = tbl_i + PA_W'({idx, {ENT_SH{1'b0}}});
endmodule

// File: rtl/xlat_entry_chk.sv
module xlat_entry_chk
  import xlat_pkg::*;
(
  input  lvl_e   lvl_i,
  input  logic   long_i,
  input  logic   nx_en_i,
  input  logic   p_i,
  input  logic   w_i,
  input  logic   u_i,
  input  logic   a_i,
  input  logic   ps_i,
  input  logic   nx_i,
  input  logic   wr_acc_i,
  input  logic   usr_acc_i,
  output fcode_e fcode_o,
  output logic   wr_acc_o,
  output logic   usr_acc_o,
  output logic   leaf_o,
  output logic   big_o,
  output logic   mark_o
);
  logic top_pae, first, nx_bad;

  // three-level pointer level: present check only, no flags touched
  assign top_pae = !long_i && (lvl_i == LV_PDP);
  assign first   = long_i ? (lvl_i == LV_TOP) : (lvl_i == LV_PD);
  assign nx_bad  = nx_i && !nx_en_i && !top_pae;

  always_comb begin
    if (nx_bad)     fcode_o = FC_NOEXEC;
    else if (!p_i)  fcode_o = FC_NOTPRES;
    else            fcode_o = FC_NONE;
  end

  assign big_o  = (lvl_i == LV_PD) && ps_i;
  assign leaf_o = (lvl_i == LV_PT) || big_o;
  assign mark_o = !a_i && !top_pae && !leaf_o;

  assign wr_acc_o  = top_pae ? wr_acc_i  : (first ? w_i : (wr_acc_i & w_i));
  assign usr_acc_o = top_pae ? usr_acc_i : (first ? u_i : (usr_acc_i & u_i));
endmodule

// File: rtl/xlat_leaf_fmt.sv
module xlat_leaf_fmt
  import xlat_pkg::*;
#(
  parameter int VPN_W = 36,
  parameter int PA_W  = 52,
  localparam int FR_W = PA_W - OFF_W
) (
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [FR_W-1:0]  frame_i,
  input  logic             big_i,
  input  logic             long_i,
  input  logic             pat7_i,
  output logic [VPN_W-1:0] vpn_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             pat_o
);
  always_comb begin
    if (big_i) begin
      vpn_o = {vpn_i[VPN_W-1:IDX_W], {IDX_W{1'b0}}};
      pa_o  = {frame_i[FR_W-1:IDX_W], {(IDX_W+OFF_W){1'b0}}};
      pat_o = frame_i[B_PAT-OFF_W];
    end else begin
      vpn_o = vpn_i;
      pa_o  = {frame_i, {OFF_W{1'b0}}};
      pat_o = long_i ? frame_i[B_PAT-OFF_W] : pat7_i;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int BASE_W = 40,
  localparam int VPN_W = VA_W - OFF_W,
  localparam int FR_W  = PA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VPN_W-1:0]  start_vpn_i,
  input  logic [BASE_W-1:0] start_base_i,
  input  logic              start_long_i,
  input  logic              start_nx_en_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [PA_W-1:0]   rd_addr_o,
  output logic              rd_nocache_o,
  input  logic              rd_vld_i,
  input  logic [ENT_W-1:0]  rd_data_i,
  output logic              wr_req_o,
  output logic [PA_W-1:0]   wr_addr_o,
  output logic [ENT_W-1:0]  wr_data_o,
  output logic              tlb_vld_o,
  output logic [VPN_W-1:0]  tlb_vpn_o,
  output logic [PA_W-1:0]   tlb_pa_o,
  output logic              tlb_big_o,
  output logic              tlb_wr_o,
  output logic              tlb_user_o,
  output logic              tlb_nx_o,
  output logic              tlb_glb_o,
  output logic              tlb_nocache_o,
  output logic              tlb_pat_o,
  output logic              fault_vld_o,
  output logic [1:0]        fault_code_o
);
  st_e              st_q;
  lvl_e             lvl_q;
  logic             long_q, nx_en_q, nx_q, wr_acc_q, usr_acc_q;
  logic [VPN_W-1:0] vpn_q;

  // shared address generator: root address when idle, next level otherwise
  logic [VPN_W-1:0] g_vpn;
  lvl_e             g_lvl;
  logic             g_long;
  logic [PA_W-1:0]  g_tbl, g_addr;

  always_comb begin
    if (st_q == ST_IDLE) begin
      g_vpn  = start_vpn_i;
      g_long = start_long_i;
      g_lvl  = start_long_i ? LV_TOP : LV_PDP;
      g_tbl  = start_long_i ? (PA_W'(start_base_i) << OFF_W)
                            : (PA_W'(start_base_i) << PAE_SH);
    end else begin
      g_vpn  = vpn_q;
      g_long = long_q;
      g_lvl  = lvl_e'(lvl_q - 2'd1);
      g_tbl  = {rd_data_i[PA_W-1:OFF_W], {OFF_W{1'b0}}};
    end
  end

  xlat_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W)) u_addr (
    .vpn_i  (g_vpn),
    .lvl_i  (g_lvl),
    .long_i (g_long),
    .tbl_i  (g_tbl),
    .addr_o (g_addr)
  );

  fcode_e fc;
  logic   wr_acc_n, usr_acc_n, leaf, big, mark;

  xlat_entry_chk u_chk (
    .lvl_i     (lvl_q),
    .long_i    (long_q),
    .nx_en_i   (nx_en_q),
    .p_i       (rd_data_i[B_PRES]),
    .w_i       (rd_data_i[B_WR]),
    .u_i       (rd_data_i[B_USR]),
    .a_i       (rd_data_i[B_ACC]),
    .ps_i      (rd_data_i[B_PS]),
    .nx_i      (rd_data_i[B_NX]),
    .wr_acc_i  (wr_acc_q),
    .usr_acc_i (usr_acc_q),
    .fcode_o   (fc),
    .wr_acc_o  (wr_acc_n),
    .usr_acc_o (usr_acc_n),
    .leaf_o    (leaf),
    .big_o     (big),
    .mark_o    (mark)
  );

  logic [VPN_W-1:0] leaf_vpn;
  logic [PA_W-1:0]  leaf_pa;
  logic             leaf_pat;

  xlat_leaf_fmt #(.VPN_W(VPN_W), .PA_W(PA_W)) u_leaf (
    .vpn_i   (vpn_q),
    .frame_i (rd_data_i[PA_W-1:OFF_W]),
    .big_i   (big),
    .long_i  (long_q),
    .pat7_i  (rd_data_i[B_PS]),
    .vpn_o   (leaf_vpn),
    .pa_o    (leaf_pa),
    .pat_o   (leaf_pat)
  );

  assign busy_o = (st_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      lvl_q         <= LV_TOP;
      long_q        <= 1'b0;
      nx_en_q       <= 1'b0;
      nx_q          <= 1'b0;
      wr_acc_q      <= 1'b1;
      usr_acc_q     <= 1'b1;
      vpn_q         <= '0;
      rd_req_o      <= 1'b0;
      rd_addr_o     <= '0;
      rd_nocache_o  <= 1'b0;
      wr_req_o      <= 1'b0;
      wr_addr_o     <= '0;
      wr_data_o     <= '0;
      tlb_vld_o     <= 1'b0;
      tlb_vpn_o     <= '0;
      tlb_pa_o      <= '0;
      tlb_big_o     <= 1'b0;
      tlb_wr_o      <= 1'b0;
      tlb_user_o    <= 1'b0;
      tlb_nx_o      <= 1'b0;
      tlb_glb_o     <= 1'b0;
      tlb_nocache_o <= 1'b0;
      tlb_pat_o     <= 1'b0;
      fault_vld_o   <= 1'b0;
      fault_code_o  <= '0;
    end else begin
      rd_req_o    <= 1'b0;
      wr_req_o    <= 1'b0;
      tlb_vld_o   <= 1'b0;
      fault_vld_o <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q         <= ST_WAIT;
            lvl_q        <= g_lvl;
            long_q       <= start_long_i;
            nx_en_q      <= start_nx_en_i;
            nx_q         <= 1'b0;
            wr_acc_q     <= 1'b1;
            usr_acc_q    <= 1'b1;
            vpn_q        <= start_vpn_i;
            rd_req_o     <= 1'b1;
            rd_addr_o    <= g_addr;
            rd_nocache_o <= 1'b0;
          end
        end
        default: begin
          if (rd_vld_i) begin
            if (fc != FC_NONE) begin
              fault_vld_o  <= 1'b1;
              fault_code_o <= fc;
              st_q         <= ST_IDLE;
            end else if (leaf) begin
              tlb_vld_o     <= 1'b1;
              tlb_vpn_o     <= leaf_vpn;
              tlb_pa_o      <= leaf_pa;
              tlb_big_o     <= big;
              tlb_wr_o      <= wr_acc_n;
              tlb_user_o    <= usr_acc_n;
              tlb_nx_o      <= nx_q;
              tlb_glb_o     <= rd_data_i[B_GLB];
              tlb_nocache_o <= rd_data_i[B_PCD];
              tlb_pat_o     <= leaf_pat;
              st_q          <= ST_IDLE;
            end else begin
              lvl_q        <= g_lvl;
              wr_acc_q     <= wr_acc_n;
              usr_acc_q    <= usr_acc_n;
              if (long_q && lvl_q == LV_TOP) nx_q <= rd_data_i[B_NX];
              rd_req_o     <= 1'b1;
              rd_addr_o    <= g_addr;
              rd_nocache_o <= rd_data_i[B_PCD];
              wr_req_o     <= mark;
              wr_addr_o    <= rd_addr_o;
              wr_data_o    <= rd_data_i | (ENT_W'(1) << B_ACC);
            end
          end
        end
      endcase
    end
  end

  p_wr_with_rd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> rd_req_o)
    else $error("write-back without a companion read");

  p_one_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tlb_vld_o && fault_vld_o))
    else $error("insert and fault in one cycle");

  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_vld_o || fault_vld_o) |-> (!busy_o && $past(busy_o)))
    else $error("walk end not aligned with busy");

  p_first_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (rd_req_o && !rd_nocache_o))
    else $error("walk start without root read");

  p_req_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o)
    else $error("read while idle");

  p_big_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tlb_vld_o && tlb_big_o) |-> (tlb_vpn_o[IDX_W-1:0] == '0))
    else $error("large page vpn not aligned");

  p_fault_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_vld_o |-> (fault_code_o != 2'd0))
    else $error("fault without code");
endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [35:0] start_vpn_i = '0;
  logic [39:0] start_base_i = '0;
  logic        start_long_i = 1'b0;
  logic        start_nx_en_i = 1'b0;
  logic        busy_o, rd_req_o, rd_nocache_o, wr_req_o;
  logic [51:0] rd_addr_o, wr_addr_o, tlb_pa_o;
  logic        rd_vld_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic [63:0] wr_data_o;
  logic        tlb_vld_o, tlb_big_o, tlb_wr_o, tlb_user_o, tlb_nx_o;
  logic        tlb_glb_o, tlb_nocache_o, tlb_pat_o, fault_vld_o;
  logic [35:0] tlb_vpn_o;
  logic [1:0]  fault_code_o;

  always #10 clk = ~clk;

  xlat_walker u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .start_i(start_i), .start_vpn_i(start_vpn_i), .start_base_i(start_base_i),
    .start_long_i(start_long_i), .start_nx_en_i(start_nx_en_i),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_nocache_o(rd_nocache_o), .rd_vld_i(rd_vld_i), .rd_data_i(rd_data_i),
    .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .tlb_vld_o(tlb_vld_o), .tlb_vpn_o(tlb_vpn_o), .tlb_pa_o(tlb_pa_o),
    .tlb_big_o(tlb_big_o), .tlb_wr_o(tlb_wr_o), .tlb_user_o(tlb_user_o),
    .tlb_nx_o(tlb_nx_o), .tlb_glb_o(tlb_glb_o), .tlb_nocache_o(tlb_nocache_o),
    .tlb_pat_o(tlb_pat_o), .fault_vld_o(fault_vld_o), .fault_code_o(fault_code_o)
  );

  localparam logic [11:0] F_P = 12'h001, F_W = 12'h002, F_U = 12'h004;
  localparam logic [11:0] F_PCD = 12'h010, F_A = 12'h020, F_PS = 12'h080, F_G = 12'h100;

  int vectors = 0;
  int miscompares = 0;

  bit [63:0] mem [bit [51:0]];

  logic [51:0] lg_rd [8];
  logic        lg_nc [8];
  logic [51:0] lg_wa [8];
  logic [63:0] lg_wd [8];
  int          n_rd, n_wr;
  logic        got_tlb, got_flt, busy_first, busy_end;
  logic [1:0]  c_fcode;
  logic [35:0] c_vpn;
  logic [51:0] c_pa;
  logic        c_big, c_wr, c_usr, c_nx, c_glb, c_nc, c_pat;

  function automatic logic [63:0] mk(input logic [51:0] pa, input logic [11:0] fl,
                                     input logic nx);
    mk = {nx, 11'b0, pa[51:12], fl};
  endfunction

  function automatic logic [63:0] mem_rd(input logic [51:0] a);
    mem_rd = mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_walk(input logic [35:0] vpn, input logic [39:0] base,
                          input logic lng, input logic nxe, input bit inj);
    int  cyc;
    logic done;
    n_rd = 0; n_wr = 0; got_tlb = 0; got_flt = 0; done = 0;
    busy_first = 0; busy_end = 1; c_fcode = 0;
    @(negedge clk);
    start_i = 1; start_vpn_i = vpn; start_base_i = base;
    start_long_i = lng; start_nx_en_i = nxe;
    @(negedge clk);
    start_i = 0;
    cyc = 0;
    while (!done && cyc < 100) begin
      start_i = inj && (cyc == 2);
      if (inj && cyc == 2) begin
        start_vpn_i = ~vpn; start_long_i = ~lng; start_base_i = ~base;
      end
      if (wr_req_o) begin
        if (n_wr < 8) begin lg_wa[n_wr] = wr_addr_o; lg_wd[n_wr] = wr_data_o; end
        n_wr++;
      end
      rd_vld_i = 0;
      if (rd_req_o) begin
        if (n_rd == 0) busy_first = busy_o;
        if (n_rd < 8) begin lg_rd[n_rd] = rd_addr_o; lg_nc[n_rd] = rd_nocache_o; end
        n_rd++;
        rd_vld_i = 1;
        rd_data_i = mem_rd(rd_addr_o);
      end
      if (tlb_vld_o) begin
        got_tlb = 1; done = 1; busy_end = busy_o;
        c_vpn = tlb_vpn_o; c_pa = tlb_pa_o; c_big = tlb_big_o; c_wr = tlb_wr_o;
        c_usr = tlb_user_o; c_nx = tlb_nx_o; c_glb = tlb_glb_o;
        c_nc = tlb_nocache_o; c_pat = tlb_pat_o;
      end
      if (fault_vld_o) begin
        got_flt = 1; done = 1; busy_end = busy_o; c_fcode = fault_code_o;
      end
      @(negedge clk);
      cyc++;
    end
    rd_vld_i = 0; start_i = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 busy", busy_o, 0);
    chk("R1 rd_req", rd_req_o, 0);
    chk("R1 wr_req", wr_req_o, 0);
    chk("R1 tlb_vld", tlb_vld_o, 0);
    chk("R1 fault_vld", fault_vld_o, 0);
  endtask

  task automatic load_long4k;
    mem.delete();
    mem[52'h123028] = mk(52'h200000, F_P | F_W | F_U | F_A, 0);
    mem[52'h200018] = mk(52'h300000, F_P | F_W | F_U | F_PCD, 0);
    mem[52'h300038] = mk(52'h400000, F_P | F_W | F_A, 0);
    mem[52'h400058] = mk(52'h98764000, F_P | F_W | F_U | F_A | F_G | F_PCD | F_PS, 0);
  endtask

  task automatic t_long4k(input bit inj);
    logic [35:0] v;
    v = {9'd5, 9'd3, 9'd7, 9'd11};
    load_long4k();
    run_walk(v, 40'h00123, 1, 0, inj);
    chk(inj ? "R10 reads" : "R3 reads", n_rd, 4);
    chk("R2 root addr", lg_rd[0], 52'h123028);
    chk("R2 busy first", busy_first, 1);
    chk("R2 busy end", busy_end, 0);
    chk("R2 root nocache", lg_nc[0], 0);
    chk("R3 addr l3", lg_rd[1], 52'h200018);
    chk("R3 addr l2", lg_rd[2], 52'h300038);
    chk("R3 addr l1", lg_rd[3], 52'h400058);
    chk("R8 nocache l2", lg_nc[2], 1);
    chk("R8 nocache l1", lg_nc[3], 0);
    chk("R4 writes", n_wr, 1);
    chk("R4 wr addr", lg_wa[0], 52'h200018);
    chk("R4 wr data", lg_wd[0], mk(52'h300000, F_P | F_W | F_U | F_PCD | F_A, 0));
    chk(inj ? "R10 tlb" : "R6 tlb", got_tlb, 1);
    chk(inj ? "R10 vpn" : "R6 vpn", c_vpn, v);
    chk("R6 pa", c_pa, 52'h98764000);
    chk("R6 big", c_big, 0);
    chk("R6 pat long", c_pat, 0);
    chk("R7 wr", c_wr, 1);
    chk("R7 user", c_usr, 0);
    chk("R7 nx", c_nx, 0);
    chk("R8 glb", c_glb, 1);
    chk("R8 tlb nocache", c_nc, 1);
  endtask

  task automatic t_long2m;
    logic [35:0] v;
    v = {9'd1, 9'd2, 9'd3, 9'd4};
    mem.delete();
    mem[52'h500008] = mk(52'h600000, F_P | F_W | F_U, 1);
    mem[52'h600010] = mk(52'h700000, F_P | F_U | F_A, 0);
    mem[52'h700018] = mk(52'h123401000, F_P | F_W | F_U | F_PS | F_PCD, 0);
    run_walk(v, 40'h00500, 1, 1, 0);
    chk("R5 reads", n_rd, 3);
    chk("R2 root addr 2m", lg_rd[0], 52'h500008);
    chk("R4 writes 2m", n_wr, 1);
    chk("R4 wr addr top", lg_wa[0], 52'h500008);
    chk("R4 wr data top", lg_wd[0], mk(52'h600000, F_P | F_W | F_U | F_A, 1));
    chk("R5 tlb", got_tlb, 1);
    chk("R5 big", c_big, 1);
    chk("R5 pa", c_pa, 52'h123400000);
    chk("R5 pat", c_pat, 1);
    chk("R5 vpn", c_vpn, {9'd1, 9'd2, 9'd3, 9'd0});
    chk("R7 wr 2m", c_wr, 0);
    chk("R7 user 2m", c_usr, 1);
    chk("R7 nx 2m", c_nx, 1);
    chk("R8 nocache 2m", c_nc, 1);
    chk("R8 glb 2m", c_glb, 0);
  endtask

  task automatic t_pae4k;
    logic [35:0] v;
    v = {16'hbeef, 2'd2, 9'd6, 9'd9};
    mem.delete();
    mem[52'h15790] = mk(52'h800000, F_P, 1);
    mem[52'h800030] = mk(52'h810000, F_P | F_W | F_U | F_A, 0);
    mem[52'h810048] = mk(52'h77777000, F_P | F_W | F_U | F_A, 0);
    run_walk(v, 40'h00abc, 0, 0, 0);
    chk("R2 pae root addr", lg_rd[0], 52'h15790);
    chk("R3 pae reads", n_rd, 3);
    chk("R3 pae addr pd", lg_rd[1], 52'h800030);
    chk("R3 pae addr pt", lg_rd[2], 52'h810048);
    chk("R9 pae top nx ignored", got_flt, 0);
    chk("R4 pae top no write", n_wr, 0);
    chk("R6 pae tlb", got_tlb, 1);
    chk("R6 pae pa", c_pa, 52'h77777000);
    chk("R6 pae pat bit7", c_pat, 0);
    chk("R7 pae wr", c_wr, 1);
    chk("R7 pae user", c_usr, 1);
    chk("R7 pae nx", c_nx, 0);
  endtask

  task automatic t_notpres;
    mem.delete();
    mem[52'h900010] = mk(52'hA00000, F_P | F_W | F_U | F_A, 0);
    mem[52'hA00010] = mk(52'hB00000, F_W | F_U, 0);
    run_walk({9'd2, 9'd2, 9'd2, 9'd2}, 40'h00900, 1, 0, 0);
    chk("R9 np fault", got_flt, 1);
    chk("R9 np code", c_fcode, 1);
    chk("R9 np no tlb", got_tlb, 0);
    chk("R9 np reads", n_rd, 2);
    chk("R9 np writes", n_wr, 0);
    chk("R9 np busy end", busy_end, 0);
  endtask

  task automatic t_nxfault;
    mem.delete();
    mem[52'hc00008] = mk(52'h0, 12'h000, 1);
    run_walk({9'd1, 27'd0}, 40'h00c00, 1, 0, 0);
    chk("R9 nx fault", got_flt, 1);
    chk("R9 nx priority code", c_fcode, 2);
    chk("R9 nx reads", n_rd, 1);
    chk("R9 nx no tlb", got_tlb, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_long4k(0);
    t_long2m();
    t_pae4k();
    t_notpres();
    t_nxfault();
    t_long4k(1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule